// File: doc/BRIEF.md
# Tone Burst Sequencer

This block produces a digital tone from a programmed frequency and a programmed burst length. A phase accumulator, clocked by the tone master clock, steps a 7-bit phase index through 128 positions per output cycle. The index is turned into an 8-bit offset-binary sample, either a sine taken from a small quarter-wave table or a square wave. A zero-cross strobe and a busy flag go with the sample. Software writes the frequency, the duration and the waveform mode through one-cycle write strobes.

A burst starts once the stored frequency and the stored duration are both non-zero. While a burst is running, software may write the next frequency and/or duration, and may overwrite them. When the current burst ends, the queued values take over without a break in phase and without the busy flag dropping. A burst never stops in the middle of a waveform. After its duration runs out, it continues to the next zero crossing or to the next complete cycle, as the finish mode selects. When a burst ends and nothing is queued, the stored duration clears to zero and the stored frequency is kept. An alternating mode repeats a pattern of one cycle at the set frequency followed by two cycles at twice that frequency.

Top module: `tone_burst_seq`

## Requirements
- R1: After reset, `busy` is 0, `phase_idx` is 0, `sample` is 128 (midscale) and `zero_cross` is 0.
- R2: A burst (`busy` = 1 from the cycle after the write) starts only when the stored frequency and the stored duration are both non-zero. Writing one value while the other is zero does not start a burst. The write that completes the pair starts it.
- R3: In each tone-clock cycle the accumulator adds frequency×128. Each time the total reaches `TCLK_HZ`, `phase_idx` advances by exactly one, so a half cycle lasts 64·`TCLK_HZ`/(freq·128) clocks. The index never moves by more than one per clock. Frequencies must satisfy freq·256 ≤ `TCLK_HZ`.
- R4: `zero_cross` is a one-clock pulse in the cycle in which `phase_idx` becomes 0 or 64 while a tone is sounding.
- R5: A burst runs for at least duration×`DUR_UNIT` clocks before it begins to finish.
- R6: The finish mode bit `mode_in[2]` selects the end point. With 1, the burst stops when the index next reaches 0 or 64. With 0, it stops only when the index wraps to 0.
- R7: Writing a duration of 0 during a burst ends it at the next end point that R6 selects, without waiting for the programmed duration.
- R8: When a burst ends with nothing queued, `busy` falls and the stored duration becomes 0, so a later frequency write alone does not start a burst. The stored frequency is kept, so a later duration write alone starts a burst at the earlier frequency.
- R9: Frequency or duration writes made during a burst are queued. At the end point, the next burst starts in the same cycle: `busy` stays 1, the index continues without a jump, and the new frequency governs the following cycles.
- R10: With `mode_in[0]` = 0, the sample is 128 + round(127·sin(2π·idx/128)) (idx 16→218, 32→255, 48→218, 64→128, 96→1, 112→38). While idle, the sample is 128.
- R11: With `mode_in[0]` = 1, the sample is 255 for idx 0..63 and 1 for idx 64..127.
- R12: With `mode_in[1]` = 1, the tone repeats one cycle at the set frequency followed by two cycles at twice that frequency. This works in both sine and square modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tone master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_freq | input | 1 | Frequency write strobe |
| freq_in | input | FREQ_W | Frequency word, 1 Hz units at the nominal clock |
| wr_dur | input | 1 | Duration write strobe |
| dur_in | input | DUR_W | Duration word in units of DUR_UNIT clocks |
| wr_mode | input | 1 | Mode write strobe |
| mode_in | input | 3 | bit0 square, bit1 alternating f/2f, bit2 finish at any zero crossing |
| phase_idx | output | 7 | Current phase index, 128 per cycle |
| sample | output | 8 | Offset-binary waveform sample |
| zero_cross | output | 1 | Pulse when the index reaches 0 or 64 |
| busy | output | 1 | A burst is running or finishing |

## Verification
The hardest case to reach is the handover. Values queued during a burst must take over exactly at the end point, while the burst is already past its duration and still waiting for the phase boundary. The stimulus writes a new frequency early in a one-unit burst and watches `busy` through the whole finishing window. It then times successive zero crossings to show that the new rate has taken over. The alternating mode is reached the same way: its full three-cycle interval pattern is timed edge to edge.

// File: rtl/tone_seq_pkg.sv
package tone_seq_pkg;

  localparam int unsigned PHASE_W  = 7;
  localparam int unsigned SAMPLE_W = 8;
  localparam logic [SAMPLE_W-1:0] SAMPLE_MID = 8'd128;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } tone_state_t;

  // round(127*sin(k*pi/64)) for k = 0..32
  function automatic logic [6:0] quarter_amp(input logic [5:0] k);
    logic [6:0] a;
    case (k)
      6'd0:  a = 7'd0;    6'd1:  a = 7'd6;    6'd2:  a = 7'd12;   6'd3:  a = 7'd19;
      6'd4:  a = 7'd25;   6'd5:  a = 7'd31;   6'd6:  a = 7'd37;   6'd7:  a = 7'd43;
      6'd8:  a = 7'd49;   6'd9:  a = 7'd54;   6'd10: a = 7'd60;   6'd11: a = 7'd65;
      6'd12: a = 7'd71;   6'd13: a = 7'd76;   6'd14: a = 7'd81;   6'd15: a = 7'd85;
      6'd16: a = 7'd90;   6'd17: a = 7'd94;   6'd18: a = 7'd98;   6'd19: a = 7'd102;
      6'd20: a = 7'd106;  6'd21: a = 7'd109;  6'd22: a = 7'd112;  6'd23: a = 7'd115;
      6'd24: a = 7'd117;  6'd25: a = 7'd120;  6'd26: a = 7'd122;  6'd27: a = 7'd123;
      6'd28: a = 7'd125;  6'd29: a = 7'd126;  6'd30: a = 7'd126;  6'd31: a = 7'd127;
      default: a = 7'd127;
    endcase
    return a;
  endfunction

  function automatic logic [SAMPLE_W-1:0] tone_sample(input logic [PHASE_W-1:0] idx,
                                                      input logic sqr);
    logic [5:0] h;
    logic [5:0] k;
    logic [6:0] a;
    if (sqr) return idx[6] ? 8'd1 : 8'd255;
    h = idx[5:0];
    k = (h > 6'd32) ? 6'(7'd64 - {1'b0, h}) : h;
    a = quarter_amp(k);
    return idx[6] ? (8'd128 - {1'b0, a}) : (8'd128 + {1'b0, a});
  endfunction

endpackage

// File: rtl/tone_phase_gen.sv
module tone_phase_gen import tone_seq_pkg::*; #(
  parameter int unsigned TCLK_HZ = 27_000_000,
  parameter int unsigned FREQ_W  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               clr,
  input  logic [FREQ_W-1:0]  freq,
  input  logic               f2f,
  output logic [PHASE_W-1:0] idx,
  output logic               step,
  output logic [PHASE_W-1:0] idx_nxt
);
  localparam int unsigned CLK_W = $clog2(TCLK_HZ) + 1;
  localparam int unsigned INC_W = FREQ_W + PHASE_W + 1;
  localparam int unsigned SUM_W = ((CLK_W > INC_W) ? CLK_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] TCLK_C = SUM_W'(TCLK_HZ);

  logic [SUM_W-1:0] acc;
  logic [SUM_W-1:0] inc;
  logic [SUM_W-1:0] sum;
  logic [1:0]       cyc;
  logic             dbl;

  assign dbl     = f2f && (cyc != 2'd0);
  assign inc     = SUM_W'({freq, {PHASE_W{1'b0}}}) << dbl;
  assign sum     = acc + inc;
  assign step    = run && (sum >= TCLK_C);
  assign idx_nxt = idx + PHASE_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      idx <= '0;
    end else if (run) begin
      if (step) begin
        acc <= sum - TCLK_C;
        idx <= idx_nxt;
      end else begin
        acc <= sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !f2f) cyc <= 2'd0;
    else if (step && idx_nxt == '0) cyc <= (cyc == 2'd2) ? 2'd0 : cyc + 2'd1;
  end

  // R3: index moves by at most one position per clock
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (idx == $past(idx) || idx == $past(idx) + PHASE_W'(1)));

  // R3: the remainder kept in the accumulator stays below one step
  a_r3_acc_bounded: assert property (@(posedge clk) disable iff (rst)
    acc < TCLK_C);

endmodule

// File: rtl/tone_dur_timer.sv
module tone_dur_timer #(
  parameter int unsigned DUR_UNIT = 2_700_000,
  parameter int unsigned DUR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DUR_W-1:0] units_in,
  input  logic             run,
  output logic             done
);
  localparam int unsigned PRE_W = (DUR_UNIT > 1) ? $clog2(DUR_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(DUR_UNIT - 1);

  logic [PRE_W-1:0] pre;
  logic [DUR_W-1:0] units;

  assign done = run && (pre == '0) && (units == DUR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre   <= '0;
      units <= '0;
    end else if (load) begin
      pre   <= PRE_TOP;
      units <= units_in;
    end else if (run) begin
      if (pre == '0) begin
        pre <= PRE_TOP;
        if (units != '0) units <= units - DUR_W'(1);
      end else begin
        pre <= pre - PRE_W'(1);
      end
    end
  end

  // R5: a running burst always has at least one unit left to count
  a_r5_units_left: assert property (@(posedge clk) disable iff (rst)
    run |-> units != '0);

endmodule

// File: rtl/tone_sample_reg.sv
module tone_sample_reg import tone_seq_pkg::*; (
  input  logic                clk,
  input  logic                rst,
  input  logic                active,
  input  logic [PHASE_W-1:0]  idx,
  input  logic                sqr,
  output logic [SAMPLE_W-1:0] sample
);
  always_ff @(posedge clk) begin
    if (rst)         sample <= SAMPLE_MID;
    else if (active) sample <= tone_sample(idx, sqr);
    else             sample <= SAMPLE_MID;
  end

  // R11: square mode only ever yields the two extreme codes
  a_r11_square_levels: assert property (@(posedge clk) disable iff (rst)
    (active && sqr) |=> (sample == 8'd255 || sample == 8'd1));

endmodule

// File: rtl/tone_burst_seq.sv
module tone_burst_seq import tone_seq_pkg::*; #(
  parameter int unsigned TCLK_HZ  = 27_000_000,
  parameter int unsigned DUR_UNIT = 2_700_000,
  parameter int unsigned FREQ_W   = 15,
  parameter int unsigned DUR_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_freq,
  input  logic [FREQ_W-1:0]   freq_in,
  input  logic                wr_dur,
  input  logic [DUR_W-1:0]    dur_in,
  input  logic                wr_mode,
  input  logic [2:0]          mode_in,
  output logic [PHASE_W-1:0]  phase_idx,
  output logic [SAMPLE_W-1:0] sample,
  output logic                zero_cross,
  output logic                busy
);
  localparam logic [PHASE_W-1:0] HALF_IDX = PHASE_W'(1 << (PHASE_W - 1));

  tone_state_t       state, nxt_state;
  logic [FREQ_W-1:0] freq_reg, act_freq, nf;
  logic [DUR_W-1:0]  dur_reg, nd;
  logic              pend, pend_now, zero_wr;
  logic              sqr_r, f2f_r, tfin_r;
  logic              start_w, hand_w, active;
  logic              pg_step, t_done, edge_hit, any_cross;
  logic [PHASE_W-1:0] pg_idx, pg_idx_nxt, idx_after;
  logic              zc_q;

  assign nf       = wr_freq ? freq_in : freq_reg;
  assign nd       = wr_dur  ? dur_in  : dur_reg;
  assign active   = (state != ST_IDLE);
  assign zero_wr  = wr_dur && (dur_in == '0);
  assign pend_now = zero_wr ? 1'b0 : (pend | wr_freq | wr_dur);

  tone_phase_gen #(.TCLK_HZ(TCLK_HZ), .FREQ_W(FREQ_W)) u_phase (
    .clk(clk), .rst(rst), .run(active), .clr(start_w), .freq(act_freq),
    .f2f(f2f_r), .idx(pg_idx), .step(pg_step), .idx_nxt(pg_idx_nxt)
  );

  tone_dur_timer #(.DUR_UNIT(DUR_UNIT), .DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst(rst), .load(start_w || hand_w), .units_in(nd),
    .run(state == ST_RUN), .done(t_done)
  );

  assign any_cross = pg_step && (pg_idx_nxt == '0 || pg_idx_nxt == HALF_IDX);
  assign edge_hit  = pg_step && (pg_idx_nxt == '0 || (tfin_r && pg_idx_nxt == HALF_IDX));

  always_comb begin
    nxt_state = state;
    start_w   = 1'b0;
    hand_w    = 1'b0;
    case (state)
      ST_IDLE: if (nf != '0 && nd != '0) begin
        start_w   = 1'b1;
        nxt_state = ST_RUN;
      end
      ST_RUN: if (zero_wr || t_done) nxt_state = ST_FIN;
      ST_FIN: if (edge_hit) begin
        if (pend_now && nf != '0 && nd != '0) begin
          hand_w    = 1'b1;
          nxt_state = ST_RUN;
        end else begin
          nxt_state = ST_IDLE;
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign idx_after = start_w ? '0 : (pg_step ? pg_idx_nxt : pg_idx);

  tone_sample_reg u_wave (
    .clk(clk), .rst(rst), .active(nxt_state != ST_IDLE),
    .idx(idx_after), .sqr(sqr_r), .sample(sample)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      freq_reg <= '0;
      dur_reg  <= '0;
      act_freq <= '0;
      pend     <= 1'b0;
      sqr_r    <= 1'b0;
      f2f_r    <= 1'b0;
      tfin_r   <= 1'b0;
      zc_q     <= 1'b0;
    end else begin
      state <= nxt_state;
      if (wr_freq) freq_reg <= freq_in;
      if (wr_mode) {tfin_r, f2f_r, sqr_r} <= mode_in;
      if (state == ST_FIN && edge_hit && !hand_w) dur_reg <= '0;
      else if (wr_dur)                            dur_reg <= dur_in;
      if (start_w || hand_w || nxt_state == ST_IDLE) pend <= 1'b0;
      else if (active)                               pend <= pend_now;
      if (start_w || hand_w) act_freq <= nf;
      zc_q <= active && any_cross;
    end
  end

  assign phase_idx  = pg_idx;
  assign zero_cross = zc_q;
  assign busy       = active;

  // R4: the strobe only ever coincides with a crossing index
  a_r4_zc_at_crossing: assert property (@(posedge clk) disable iff (rst)
    zero_cross |-> (phase_idx == '0 || phase_idx == HALF_IDX));

  // R10: an idle block outputs midscale
  a_r10_idle_midscale: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sample == SAMPLE_MID);

  // R8: a burst that ends without a queued value leaves no duration behind
  a_r8_dur_cleared: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_FIN) |-> dur_reg == '0);

  // R2: a running burst always has a non-zero frequency behind it
  a_r2_run_has_freq: assert property (@(posedge clk) disable iff (rst)
    busy |-> act_freq != '0);

endmodule

// File: tb/tone_burst_seq_tb.sv
module tone_burst_seq_tb;
  localparam int unsigned TCLK_HZ  = 2560;
  localparam int unsigned DUR_UNIT = 300;
  localparam int VEC_N = 4;
  // stimulus: frequency, duration, mode {tfin,f2f,sqr}; expected half-cycle clocks
  localparam int T_FREQ [VEC_N] = '{5, 10, 20, 10};
  localparam int T_DUR  [VEC_N] = '{2, 3, 1, 1};
  localparam int T_MODE [VEC_N] = '{0, 1, 4, 5};
  localparam int T_HALF [VEC_N] = '{256, 128, 64, 128};
  localparam int F2F_EXP[6] = '{256, 128, 128, 128, 128, 256};

  logic clk = 1'b0;
  logic rst;
  logic wr_freq, wr_dur, wr_mode;
  logic [14:0] freq_in;
  logic [7:0]  dur_in;
  logic [2:0]  mode_in;
  logic [6:0]  phase_idx;
  logic [7:0]  sample;
  logic        zero_cross, busy;

  int checks = 0, fails = 0;
  int sine_chk = 0, sine_bad = 0, sq_chk = 0, sq_bad = 0;
  bit cur_sqr = 1'b0;

  always #2 clk = ~clk;

  tone_burst_seq #(.TCLK_HZ(TCLK_HZ), .DUR_UNIT(DUR_UNIT)) u_dut (
    .clk(clk), .rst(rst), .wr_freq(wr_freq), .freq_in(freq_in),
    .wr_dur(wr_dur), .dur_in(dur_in), .wr_mode(wr_mode), .mode_in(mode_in),
    .phase_idx(phase_idx), .sample(sample), .zero_cross(zero_cross), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_freq(input int f);
    @(negedge clk); wr_freq = 1'b1; freq_in = 15'(f);
    @(negedge clk); wr_freq = 1'b0;
  endtask

  task automatic write_dur(input int d);
    @(negedge clk); wr_dur = 1'b1; dur_in = 8'(d);
    @(negedge clk); wr_dur = 1'b0;
  endtask

  task automatic write_mode(input int m);
    @(negedge clk); wr_mode = 1'b1; mode_in = 3'(m); cur_sqr = m[0];
    @(negedge clk); wr_mode = 1'b0;
  endtask

  // R10 / R11: compare the sample against the expected code for known indices
  task automatic look_sample();
    int e;
    if (!busy) return;
    if (cur_sqr) begin
      e = phase_idx[6] ? 1 : 255;
      sq_chk++;
      if (int'(sample) != e) sq_bad++;
    end else begin
      case (phase_idx)
        7'd0, 7'd64: e = 128;
        7'd16, 7'd48: e = 218;
        7'd32: e = 255;
        7'd80, 7'd112: e = 38;
        7'd96: e = 1;
        default: e = -1;
      endcase
      if (e >= 0) begin
        sine_chk++;
        if (int'(sample) != e) sine_bad++;
      end
    end
  endtask

  task automatic wait_zc(output int n);
    n = 0;
    do begin
      @(negedge clk); n++; look_sample();
    end while (!zero_cross && n < 5000);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk); n++; look_sample();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, a, b, c, cnt;
    rst = 1'b1; wr_freq = 1'b0; wr_dur = 1'b0; wr_mode = 1'b0;
    freq_in = '0; dur_in = '0; mode_in = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(phase_idx == 7'd0, "R1 phase_idx after reset", phase_idx, 0);
    check(sample == 8'd128, "R1 sample after reset", sample, 128);
    check(zero_cross == 1'b0, "R1 zero_cross after reset", zero_cross, 0);

    // R2: duration alone with zero frequency must not start
    write_mode(0);
    write_dur(2);
    cnt = 0;
    repeat (8) begin @(negedge clk); if (busy) cnt++; end
    check(cnt == 0, "R2 no start with zero frequency", cnt, 0);
    write_freq(5);
    check(busy == 1'b1, "R2 frequency completes the pair and starts", busy, 1);
    wait_idle(n);

    // table of vectors: R3 R5 R6 R10 R11
    for (int i = 0; i < VEC_N; i++) begin
      write_mode(T_MODE[i]);
      write_freq(T_FREQ[i]);
      check(busy == 1'b0, "R8 idle frequency write does not start", busy, 0);
      write_dur(T_DUR[i]);
      check(busy == 1'b1, "R2 burst started", busy, 1);
      wait_zc(a);
      wait_zc(b);
      check(b == T_HALF[i], "R3 half-cycle interval", b, T_HALF[i]);
      wait_idle(c);
      n = 1 + a + b + c;
      check(n >= T_DUR[i] * int'(DUR_UNIT), "R5 burst not shorter than duration",
            n, T_DUR[i] * int'(DUR_UNIT));
      check(n <= T_DUR[i] * int'(DUR_UNIT) + 2 * T_HALF[i] + 8,
            "R6 finish within one cycle", n, T_DUR[i] * int'(DUR_UNIT) + 2 * T_HALF[i]);
      if (T_MODE[i] >= 4)
        check(phase_idx == 7'd0 || phase_idx == 7'd64, "R6 ends at zero crossing",
              phase_idx, 64);
      else
        check(phase_idx == 7'd0, "R6 ends at full cycle", phase_idx, 0);
      @(negedge clk);
      check(sample == 8'd128, "R10 idle sample midscale", sample, 128);
      check(zero_cross == 1'b0, "R4 strobe is one clock wide", zero_cross, 0);
    end

    // R8: duration cleared, frequency retained
    write_freq(20);
    cnt = 0;
    repeat (8) begin @(negedge clk); if (busy) cnt++; end
    check(cnt == 0, "R8 duration cleared after burst", cnt, 0);
    write_dur(1);
    check(busy == 1'b1, "R8 duration write restarts", busy, 1);
    wait_zc(a);
    wait_zc(b);
    check(b == 64, "R8 retained frequency used", b, 64);
    wait_idle(n);

    // R7: zero duration mid-burst
    write_mode(4);
    write_freq(5);
    write_dur(10);
    repeat (100) @(negedge clk);
    write_dur(0);
    wait_idle(n);
    check(n < 200, "R7 zero duration stops early", n, 154);
    check(phase_idx == 7'd64, "R7 stop at next zero crossing", phase_idx, 64);

    // R9: queued frequency handover
    write_mode(0);
    write_dur(1);
    repeat (50) @(negedge clk);
    write_freq(10);
    cnt = 0;
    repeat (560) begin @(negedge clk); if (!busy) cnt++; end
    check(cnt == 0, "R9 busy held through handover", cnt, 0);
    wait_zc(a);
    wait_zc(b);
    check(b == 128, "R9 new frequency after handover", b, 128);
    wait_idle(n);
    check(phase_idx == 7'd0, "R9 second burst ends on full cycle", phase_idx, 0);

    // R12: alternating f / 2f pattern
    write_mode(2);
    write_freq(5);
    write_dur(5);
    wait_zc(a);
    for (int k = 0; k < 6; k++) begin
      wait_zc(b);
      check(b == F2F_EXP[k], "R12 alternating interval", b, F2F_EXP[k]);
    end
    wait_idle(n);

    check(sine_chk > 0 && sine_bad == 0, "R10 sine sample codes", sine_bad, 0);
    check(sq_chk > 0 && sq_bad == 0, "R11 square sample codes", sq_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule